// File: doc/BRIEF.md
# Synchronous Trap Arbiter for a Register-Window Integer Pipeline

This block sits in the exception stage of a 32-bit integer pipeline that uses register windows. On every clock it reads the decoded instruction-class flags and the processor status bits. It also reads the current window pointer, the window invalid mask, the computed memory and jump addresses, the operand tag bits, the overflow flag, the divisor and the external error strobes. From these it works out which trap conditions are active and picks the single most urgent one.

The result is registered. One cycle after the inputs are presented, the block shows a trap strobe and an 8-bit trap code. An external reset request also raises a redirect to address 0 and forces the supervisor and enable-traps values. A window pointer update is offered, modulo the window count. It is applied only when no trap is taken. The pipeline flush, the register file and the memory system sit outside this block.

Top module: `trap_arbiter`

## Requirements
- R1: While `rst_n` is low the outputs are `trap_taken`=0, `trap_type`=0x00, `reset_redirect`=0, `new_s`=1, `new_et`=0 and `cwp_next`=0.
- R2: When `ext_rst_req` is 1 at a clock edge, the block shows the following after that edge: `trap_taken`=1, `reset_redirect`=1, `trap_type`=0x00, `new_s`=1 and `new_et`=0. Otherwise `new_s` and `new_et` copy `psr_s` and `psr_et`.
- R3: `is_priv` with `psr_s`=0 gives code 0x03. With `psr_s`=1 it gives no trap.
- R4: `is_fpop` gives 0x04 when `psr_ef`=0 or `fpu_present`=0. `is_cpop` gives 0x24 when `psr_ec`=0 or `cp_present`=0.
- R5: `is_save` gives 0x05 when bit ((`cwp`-1) mod NWIN) of `wim` is 1. `is_restore` or `is_rett` gives 0x06 when bit ((`cwp`+1) mod NWIN) of `wim` is 1.
- R6: A memory access (`mem_op`=1) whose `mem_addr` is not a multiple of its size gives 0x07. The size code `mem_size` is 0 for a byte, 1 for a halfword, 2 for a word and 3 for a doubleword. A `jump_target` with nonzero bits [1:0] gives 0x07 when `is_jmpl` or `is_rett` is 1.
- R7: `is_tagged` gives 0x0A when `alu_ovf` is 1 or either 2-bit operand tag is nonzero.
- R8: `is_div` with a zero `divisor` gives 0x2A. `is_ticc` with `ticc_true`=1 gives 0x80 + `ticc_num`.
- R9: The strobes map to these codes: `err_write` 0x2B, `err_iaccess` 0x01, `err_regfile` 0x20, `is_illegal` 0x02, `fp_exc` 0x08, `err_daccess` 0x09, `watch_hit` 0x0B.
- R10: When several conditions are active, only the first in this list is reported: external reset, write error, instruction access, register error, illegal, privileged, fp disabled, cp disabled, window overflow, window underflow, misaligned, fp exception, data access, tag overflow, divide by zero, trap instruction, watchpoint.
- R11: With no trap taken, `cwp_next` is (`cwp`-1) mod NWIN for `is_save` and (`cwp`+1) mod NWIN for `is_restore` or `is_rett`. In every other case, including a taken trap, it equals `cwp`.
- R12: All outputs change one clock after their inputs. With no active condition, `trap_taken`=0 and `trap_type`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rst_req | input | 1 | External reset trap request |
| err_write | input | 1 | Store error strobe |
| err_iaccess | input | 1 | Instruction fetch error strobe |
| err_regfile | input | 1 | Register file uncorrectable error |
| err_daccess | input | 1 | Load/store access error |
| fp_exc | input | 1 | FPU exception report |
| watch_hit | input | 1 | Watchpoint address match |
| is_illegal | input | 1 | Unimplemented or illegal instruction |
| is_priv | input | 1 | Privileged instruction |
| is_fpop | input | 1 | FPU instruction |
| is_cpop | input | 1 | Coprocessor instruction |
| is_save | input | 1 | Window save |
| is_restore | input | 1 | Window restore |
| is_rett | input | 1 | Return from trap |
| is_jmpl | input | 1 | Register-indirect jump |
| is_tagged | input | 1 | Tagged arithmetic with trap |
| is_div | input | 1 | Integer divide |
| is_ticc | input | 1 | Conditional software trap |
| ticc_true | input | 1 | Software trap condition holds |
| ticc_num | input | 7 | Software trap number |
| mem_op | input | 1 | Load or store present |
| mem_size | input | 2 | Access size code |
| mem_addr | input | 32 | Load/store address |
| jump_target | input | 32 | Jump or return target |
| psr_s | input | 1 | Supervisor bit |
| psr_et | input | 1 | Enable-traps bit |
| psr_ef | input | 1 | FPU enable |
| psr_ec | input | 1 | Coprocessor enable |
| fpu_present | input | 1 | FPU fitted |
| cp_present | input | 1 | Coprocessor fitted |
| cwp | input | $clog2(NWIN) | Current window pointer |
| wim | input | NWIN | Window invalid mask |
| op_a_tag | input | 2 | Tag bits of operand A |
| op_b_tag | input | 2 | Tag bits of operand B |
| alu_ovf | input | 1 | Arithmetic overflow |
| divisor | input | 32 | Divide operand |
| trap_taken | output | 1 | A trap is taken |
| trap_type | output | 8 | Code of the taken trap |
| reset_redirect | output | 1 | Restart at address 0 |
| new_s | output | 1 | Supervisor bit to write back |
| new_et | output | 1 | Enable-traps bit to write back |
| cwp_next | output | $clog2(NWIN) | Window pointer to commit |

## Verification
The assertions assume that `cwp` is always below NWIN. They also assume that at most one of `is_save`, `is_restore` and `is_rett` is high in a cycle, because the block gives no defined result when they overlap. The bench keeps to both rules. Its random stimulus draws `cwp` modulo NWIN and picks a single window operation per cycle. The other flags are raised sparsely so that lower-priority codes still appear. Directed cycles then set every condition at once and clear them one at a time, from the highest priority down.

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int NWIN = 8,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_rst_req,
  input  logic          err_write,
  input  logic          err_iaccess,
  input  logic          err_regfile,
  input  logic          err_daccess,
  input  logic          fp_exc,
  input  logic          watch_hit,
  input  logic          is_illegal,
  input  logic          is_priv,
  input  logic          is_fpop,
  input  logic          is_cpop,
  input  logic          is_save,
  input  logic          is_restore,
  input  logic          is_rett,
  input  logic          is_jmpl,
  input  logic          is_tagged,
  input  logic          is_div,
  input  logic          is_ticc,
  input  logic          ticc_true,
  input  logic [6:0]    ticc_num,
  input  logic          mem_op,
  input  logic [1:0]    mem_size,
  input  logic [31:0]   mem_addr,
  input  logic [31:0]   jump_target,
  input  logic          psr_s,
  input  logic          psr_et,
  input  logic          psr_ef,
  input  logic          psr_ec,
  input  logic          fpu_present,
  input  logic          cp_present,
  input  logic [CW-1:0] cwp,
  input  logic [NWIN-1:0] wim,
  input  logic [1:0]    op_a_tag,
  input  logic [1:0]    op_b_tag,
  input  logic          alu_ovf,
  input  logic [31:0]   divisor,
  output logic          trap_taken,
  output logic [7:0]    trap_type,
  output logic          reset_redirect,
  output logic          new_s,
  output logic          new_et,
  output logic [CW-1:0] cwp_next
);

  logic [CW-1:0] cwp_dec, cwp_inc;
  assign cwp_dec = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
  assign cwp_inc = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;

  logic priv_c, fpd_c, cpd_c, wovf_c, wunf_c, mis_c, tag_c, dz_c, ticc_c;
  logic mis_mem;

  assign priv_c = is_priv & ~psr_s;
  assign fpd_c  = is_fpop & ~(psr_ef & fpu_present);
  assign cpd_c  = is_cpop & ~(psr_ec & cp_present);
  assign wovf_c = is_save & wim[cwp_dec];
  assign wunf_c = (is_restore | is_rett) & wim[cwp_inc];

  always_comb begin
    unique case (mem_size)
      2'd0: mis_mem = 1'b0;
      2'd1: mis_mem = mem_addr[0];
      2'd2: mis_mem = |mem_addr[1:0];
      default: mis_mem = |mem_addr[2:0];
    endcase
  end

  assign mis_c  = (mem_op & mis_mem) | ((is_jmpl | is_rett) & |jump_target[1:0]);
  assign tag_c  = is_tagged & (alu_ovf | |op_a_tag | |op_b_tag);
  assign dz_c   = is_div & (divisor == 32'd0);
  assign ticc_c = is_ticc & ticc_true;

  logic       take;
  logic [7:0] code;

  always_comb begin
    take = 1'b1;
    code = 8'h00;
    if      (ext_rst_req) code = 8'h00;
    else if (err_write)   code = 8'h2B;
    else if (err_iaccess) code = 8'h01;
    else if (err_regfile) code = 8'h20;
    else if (is_illegal)  code = 8'h02;
    else if (priv_c)      code = 8'h03;
    else if (fpd_c)       code = 8'h04;
    else if (cpd_c)       code = 8'h24;
    else if (wovf_c)      code = 8'h05;
    else if (wunf_c)      code = 8'h06;
    else if (mis_c)       code = 8'h07;
    else if (fp_exc)      code = 8'h08;
    else if (err_daccess) code = 8'h09;
    else if (tag_c)       code = 8'h0A;
    else if (dz_c)        code = 8'h2A;
    else if (ticc_c)      code = {1'b1, ticc_num};
    else if (watch_hit)   code = 8'h0B;
    else                  take = 1'b0;
  end

  logic [CW-1:0] cwp_d;
  always_comb begin
    if (take)                       cwp_d = cwp;
    else if (is_save)               cwp_d = cwp_dec;
    else if (is_restore | is_rett)  cwp_d = cwp_inc;
    else                            cwp_d = cwp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_taken     <= 1'b0;
      trap_type      <= 8'h00;
      reset_redirect <= 1'b0;
      new_s          <= 1'b1;
      new_et         <= 1'b0;
      cwp_next       <= '0;
    end else begin
      trap_taken     <= take;
      trap_type      <= code;
      reset_redirect <= ext_rst_req;
      new_s          <= ext_rst_req | psr_s;
      new_et         <= ~ext_rst_req & psr_et;
      cwp_next       <= cwp_d;
    end
  end

  // R2
  reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_req |=> (trap_taken && reset_redirect && trap_type == 8'h00 && new_s && !new_et));

  // R2
  redirect_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_redirect |-> trap_taken);

  // R10
  write_err_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_write && !ext_rst_req) |=> (trap_taken && trap_type == 8'h2B));

  // R3
  priv_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_priv && !psr_s) |=> trap_taken);

  // R8
  div_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_div && divisor == 32'd0) |=> trap_taken);

  // R8
  ticc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ticc && ticc_true) |=> trap_taken);

  // R11
  cwp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_req |=> (cwp_next == $past(cwp)));

  // R12
  idle_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_taken |-> (trap_type == 8'h00 && !reset_redirect));

endmodule

// File: tb/trap_arbiter_test.sv
`timescale 1ns/1ps
module trap_arbiter_test;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ext_rst_req, err_write, err_iaccess, err_regfile, err_daccess, fp_exc, watch_hit;
  logic is_illegal, is_priv, is_fpop, is_cpop, is_save, is_restore, is_rett, is_jmpl;
  logic is_tagged, is_div, is_ticc, ticc_true, mem_op;
  logic [6:0] ticc_num;
  logic [1:0] mem_size, op_a_tag, op_b_tag;
  logic [31:0] mem_addr, jump_target, divisor;
  logic psr_s, psr_et, psr_ef, psr_ec, fpu_present, cp_present, alu_ovf;
  logic [2:0] cwp;
  logic [NW-1:0] wim;
  logic trap_taken, reset_redirect, new_s, new_et;
  logic [7:0] trap_type;
  logic [2:0] cwp_next;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  trap_arbiter #(.NWIN(NW)) uut (
    .clk, .rst_n, .ext_rst_req, .err_write, .err_iaccess, .err_regfile, .err_daccess,
    .fp_exc, .watch_hit, .is_illegal, .is_priv, .is_fpop, .is_cpop, .is_save,
    .is_restore, .is_rett, .is_jmpl, .is_tagged, .is_div, .is_ticc, .ticc_true,
    .ticc_num, .mem_op, .mem_size, .mem_addr, .jump_target, .psr_s, .psr_et,
    .psr_ef, .psr_ec, .fpu_present, .cp_present, .cwp, .wim, .op_a_tag, .op_b_tag,
    .alu_ovf, .divisor, .trap_taken, .trap_type, .reset_redirect, .new_s, .new_et,
    .cwp_next);

  task automatic quiet();
    {ext_rst_req, err_write, err_iaccess, err_regfile, err_daccess, fp_exc, watch_hit} = '0;
    {is_illegal, is_priv, is_fpop, is_cpop, is_save, is_restore, is_rett, is_jmpl} = '0;
    {is_tagged, is_div, is_ticc, ticc_true, mem_op, alu_ovf} = '0;
    ticc_num = 0; mem_size = 0; op_a_tag = 0; op_b_tag = 0;
    mem_addr = 0; jump_target = 0; divisor = 32'd5;
    psr_s = 1; psr_et = 1; psr_ef = 1; psr_ec = 1; fpu_present = 1; cp_present = 1;
    cwp = 3'd3; wim = '0;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: list of active codes in priority order, first one wins.
  task automatic predict(output int tk, output int ty, output int rr, output int s,
                         output int et, output int cw);
    int q[$];
    int bytes;
    int up, dn;
    dn = (int'(cwp) + NW - 1) % NW;
    up = (int'(cwp) + 1) % NW;
    bytes = 1 << mem_size;
    if (ext_rst_req) q.push_back(8'h00);
    if (err_write) q.push_back(8'h2B);
    if (err_iaccess) q.push_back(8'h01);
    if (err_regfile) q.push_back(8'h20);
    if (is_illegal) q.push_back(8'h02);
    if (is_priv && psr_s == 0) q.push_back(8'h03);
    if (is_fpop && (psr_ef == 0 || fpu_present == 0)) q.push_back(8'h04);
    if (is_cpop && (psr_ec == 0 || cp_present == 0)) q.push_back(8'h24);
    if (is_save && wim[dn]) q.push_back(8'h05);
    if ((is_restore || is_rett) && wim[up]) q.push_back(8'h06);
    if ((mem_op && (mem_addr % bytes) != 0) || ((is_jmpl || is_rett) && (jump_target % 4) != 0))
      q.push_back(8'h07);
    if (fp_exc) q.push_back(8'h08);
    if (err_daccess) q.push_back(8'h09);
    if (is_tagged && (alu_ovf || op_a_tag != 0 || op_b_tag != 0)) q.push_back(8'h0A);
    if (is_div && divisor == 0) q.push_back(8'h2A);
    if (is_ticc && ticc_true) q.push_back(128 + ticc_num);
    if (watch_hit) q.push_back(8'h0B);
    tk = (q.size() > 0);
    ty = tk ? q[0] : 0;
    rr = ext_rst_req;
    s  = ext_rst_req ? 1 : psr_s;
    et = ext_rst_req ? 0 : psr_et;
    if (tk) cw = cwp;
    else if (is_save) cw = dn;
    else if (is_restore || is_rett) cw = up;
    else cw = cwp;
  endtask

  task automatic step(string req);
    int tk, ty, rr, s, et, cw;
    predict(tk, ty, rr, s, et, cw);
    @(posedge clk);
    #2;
    chk(req, "trap_taken", trap_taken, tk);
    chk(req, "trap_type", trap_type, ty);
    chk(req, "reset_redirect", reset_redirect, rr);
    chk(req, "new_s", new_s, s);
    chk(req, "new_et", new_et, et);
    chk(req, "cwp_next", cwp_next, cw);
  endtask

  task automatic expect_code(string req, int code);
    step(req);
    chk(req, "code", trap_type, code);
  endtask

  task automatic all_on();
    ext_rst_req = 1; err_write = 1; err_iaccess = 1; err_regfile = 1; is_illegal = 1;
    is_priv = 1; psr_s = 0; is_fpop = 1; psr_ef = 0; is_cpop = 1; psr_ec = 0;
    is_save = 1; cwp = 3'd0; wim = 8'hFF; mem_op = 1; mem_size = 2; mem_addr = 32'h2;
    fp_exc = 1; err_daccess = 1; is_tagged = 1; alu_ovf = 1; is_div = 1; divisor = 0;
    is_ticc = 1; ticc_true = 1; ticc_num = 7'h11; watch_hit = 1;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    quiet();
    #20;
    // R1 reset state
    chk("R1", "trap_taken", trap_taken, 0);
    chk("R1", "trap_type", trap_type, 0);
    chk("R1", "reset_redirect", reset_redirect, 0);
    chk("R1", "new_s", new_s, 1);
    chk("R1", "new_et", new_et, 0);
    chk("R1", "cwp_next", cwp_next, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;

    quiet(); step("R12");
    quiet(); psr_s = 0; psr_et = 1; step("R2");
    quiet(); ext_rst_req = 1; psr_s = 0; psr_et = 1; expect_code("R2", 8'h00);
    chk("R2", "redirect", reset_redirect, 1);

    quiet(); is_priv = 1; psr_s = 0; expect_code("R3", 8'h03);
    quiet(); is_priv = 1; psr_s = 1; step("R3");
    chk("R3", "no trap", trap_taken, 0);

    quiet(); is_fpop = 1; psr_ef = 0; expect_code("R4", 8'h04);
    quiet(); is_fpop = 1; fpu_present = 0; expect_code("R4", 8'h04);
    quiet(); is_fpop = 1; step("R4");
    quiet(); is_cpop = 1; cp_present = 0; expect_code("R4", 8'h24);
    quiet(); is_cpop = 1; psr_ec = 0; expect_code("R4", 8'h24);

    quiet(); is_save = 1; cwp = 0; wim = 8'h80; expect_code("R5", 8'h05);
    quiet(); is_restore = 1; cwp = 7; wim = 8'h01; expect_code("R5", 8'h06);
    quiet(); is_rett = 1; cwp = 2; wim = 8'h08; expect_code("R5", 8'h06);
    quiet(); is_save = 1; cwp = 0; wim = 8'h01; step("R11");
    chk("R11", "wrap down", cwp_next, 7);
    quiet(); is_restore = 1; cwp = 7; wim = 8'h80; step("R11");
    chk("R11", "wrap up", cwp_next, 0);

    for (int sz = 0; sz < 4; sz++)
      for (int a = 0; a < 8; a++) begin
        quiet(); mem_op = 1; mem_size = sz[1:0]; mem_addr = 32'h1000 + a; step("R6");
      end
    quiet(); is_jmpl = 1; jump_target = 32'h403; expect_code("R6", 8'h07);
    quiet(); is_jmpl = 1; jump_target = 32'h404; step("R6");

    quiet(); is_tagged = 1; alu_ovf = 1; expect_code("R7", 8'h0A);
    quiet(); is_tagged = 1; op_b_tag = 2'b10; expect_code("R7", 8'h0A);
    quiet(); is_tagged = 1; step("R7");

    quiet(); is_div = 1; divisor = 0; expect_code("R8", 8'h2A);
    quiet(); is_ticc = 1; ticc_true = 1; ticc_num = 7'h7F; expect_code("R8", 8'hFF);
    quiet(); is_ticc = 1; ticc_true = 0; step("R8");

    quiet(); err_write = 1; expect_code("R9", 8'h2B);
    quiet(); err_iaccess = 1; expect_code("R9", 8'h01);
    quiet(); err_regfile = 1; expect_code("R9", 8'h20);
    quiet(); is_illegal = 1; expect_code("R9", 8'h02);
    quiet(); fp_exc = 1; expect_code("R9", 8'h08);
    quiet(); err_daccess = 1; expect_code("R9", 8'h09);
    quiet(); watch_hit = 1; expect_code("R9", 8'h0B);

    // R10: strip conditions from the top down
    quiet(); all_on(); expect_code("R10", 8'h00);
    ext_rst_req = 0; expect_code("R10", 8'h2B);
    err_write = 0;   expect_code("R10", 8'h01);
    err_iaccess = 0; expect_code("R10", 8'h20);
    err_regfile = 0; expect_code("R10", 8'h02);
    is_illegal = 0;  expect_code("R10", 8'h03);
    is_priv = 0;     expect_code("R10", 8'h04);
    is_fpop = 0;     expect_code("R10", 8'h24);
    is_cpop = 0;     expect_code("R10", 8'h05);
    is_save = 0; is_restore = 1; expect_code("R10", 8'h06);
    is_restore = 0;  expect_code("R10", 8'h07);
    mem_op = 0;      expect_code("R10", 8'h08);
    fp_exc = 0;      expect_code("R10", 8'h09);
    err_daccess = 0; expect_code("R10", 8'h0A);
    is_tagged = 0;   expect_code("R10", 8'h2A);
    is_div = 0;      expect_code("R10", 8'h91);
    is_ticc = 0;     expect_code("R10", 8'h0B);
    watch_hit = 0;   step("R12");
    chk("R12", "idle", trap_taken, 0);

    for (int i = 0; i < 400; i++) begin
      int w;
      quiet();
      ext_rst_req = ($urandom % 40) == 0; err_write = ($urandom % 20) == 0;
      err_iaccess = ($urandom % 20) == 0; err_regfile = ($urandom % 20) == 0;
      err_daccess = ($urandom % 12) == 0; fp_exc = ($urandom % 12) == 0;
      watch_hit = ($urandom % 6) == 0; is_illegal = ($urandom % 20) == 0;
      is_priv = ($urandom % 6) == 0; is_fpop = ($urandom % 6) == 0; is_cpop = ($urandom % 6) == 0;
      w = $urandom % 5;
      is_save = (w == 1); is_restore = (w == 2); is_rett = (w == 3);
      is_jmpl = ($urandom % 6) == 0; is_tagged = ($urandom % 6) == 0;
      is_div = ($urandom % 6) == 0; is_ticc = ($urandom % 6) == 0;
      ticc_true = $urandom; ticc_num = $urandom; mem_op = ($urandom % 3) == 0;
      mem_size = $urandom; mem_addr = $urandom; jump_target = $urandom;
      psr_s = $urandom; psr_et = $urandom; psr_ef = $urandom; psr_ec = $urandom;
      fpu_present = ($urandom % 4) != 0; cp_present = ($urandom % 4) != 0;
      cwp = 3'($urandom % NW); wim = 8'($urandom) & 8'($urandom);
      op_a_tag = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      op_b_tag = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      alu_ovf = ($urandom % 5) == 0;
      divisor = ($urandom % 3 == 0) ? 32'd0 : $urandom;
      step("R10");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule